// File: doc/BRIEF.md
# Eight-Bit Timer with Two Waveform Channels

The block is an 8-bit counter that advances once for every clock cycle in which its count-enable input is high. A 3-bit mode field chooses how it counts and where its period ends: plain wrap at the all-ones value, clear on a compare value (the period set by compare channel A), fast PWM that only counts up, or phase-correct PWM that counts up and then down. Two compare channels, A and B, each compare the count with their own register. On a match they set their own flag and drive a waveform pin according to a 2-bit output-action field.

Each compare register is written into a buffer. It reaches the comparator at once, at the bottom of the period, or at the top, depending on the mode, so a PWM duty-cycle change never splits a period. Software reaches every register through one synchronous write port and a combinational read port. A write-only force register injects a compare event on a channel without setting its flag or ending a period.

Top module: `wavetimer8`

## Requirements
- R1: Registers: address 0 config (mode in [2:0], channel A action in [4:3], channel B action in [6:5]), 1 force (bit 0 channel A, bit 1 channel B), 2 count, 3 compare A, 4 compare B, 5 flags (bit 0 overflow, bit 1 match A, bit 2 match B). After reset every register reads zero and both pins are low.
- R2: In modes 0 (plain), 2 (clear on compare) and 3 (fast PWM) the count rises by one per enabled cycle. The overflow flag sets on the enabled cycle in which the count leaves 0xFF.
- R3: In mode 2 the count returns to zero on the enabled cycle after it equals active compare A. A channel's match flag sets on the enabled cycle in which the count equals its active compare value.
- R4: In modes 3 and 7 the count rises to its top (0xFF in mode 3, compare A in mode 7) and then restarts at zero. In mode 7 the overflow flag sets on the cycle that leaves the top.
- R5: In modes 1 and 5 (phase-correct, top 0xFF and compare A respectively) the count rises to the top, falls to zero and turns again. The overflow flag sets on the cycle that leaves zero while falling.
- R6: A compare write is used at once in modes 0 and 2, at the wrap to zero in modes 3 and 7, and at the top turn in modes 1 and 5. Reading a compare address returns the last written value.
- R7: In modes 0 and 2, action 01 toggles the pin on a match, 10 drives it low and 11 drives it high.
- R8: In modes 3 and 7, action 10 drives the pin low on a match and high at the wrap to zero, and 11 does the reverse. When both happen on the same cycle, the wrap action wins.
- R9: In modes 1 and 5, action 10 drives the pin low on a match while rising and high on a match while falling, and 11 does the reverse.
- R10: Writing 1 to a force bit in mode 0 or 2 applies that channel's match action at once. It sets no flag and does not move the count. In PWM modes the force write has no effect. The force address always reads zero.
- R11: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. A flag event on the same cycle as the clear wins.
- R12: A count write suppresses compare matches on the next enabled cycle. Period ends and overflow still happen on that cycle.
- R13: With action 00 the channel pin is held low, and the internal pin state is kept for when the action is changed again.
- R14: In modes 4 and 6 the count does not move and no flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable, one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |

## Verification
The bench writes a new compare value in the middle of a fast PWM period and checks that the old value still ends the pulse; a design with no buffer would cut that period short at the new value. It makes compare A equal the top in mode 7, where a design that let the match win over the wrap would hold the pin low. It checks that the phase-correct turn and the overflow both fall on the zero crossing, where an off-by-one turn would shift both the overflow and the falling-edge set. It also checks that a force write in a PWM mode leaves the pin alone, and that a count write set exactly on the compare value hides that one match while a clear-on-compare period still ends there.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef enum logic [1:0] {CLS_PLAIN, CLS_FAST, CLS_PHASE, CLS_HALT} mode_cls_t;
  typedef enum logic [1:0] {OV_MAX, OV_TOP, OV_BOT, OV_NONE} ovf_pt_t;

  // counting family of a 3-bit mode value
  function automatic mode_cls_t cls_of(input logic [2:0] m);
    case (m)
      3'd0, 3'd2: return CLS_PLAIN;
      3'd3, 3'd7: return CLS_FAST;
      3'd1, 3'd5: return CLS_PHASE;
      default:    return CLS_HALT;
    endcase
  endfunction

  // modes whose period end comes from compare A
  function automatic logic top_from_cmp(input logic [2:0] m);
    return (m == 3'd2) || (m == 3'd5) || (m == 3'd7);
  endfunction

  // where the overflow flag is raised
  function automatic ovf_pt_t ovf_point(input logic [2:0] m);
    case (m)
      3'd0, 3'd2, 3'd3: return OV_MAX;
      3'd7:             return OV_TOP;
      3'd1, 3'd5:       return OV_BOT;
      default:          return OV_NONE;
    endcase
  endfunction

  // next pin state for one channel
  function automatic logic wave_next(input mode_cls_t cls, input logic [1:0] act,
                                     input logic cur, input logic hit,
                                     input logic wrap, input logic rising);
    logic nxt;
    nxt = cur;
    case (cls)
      CLS_PLAIN: if (hit) begin
        case (act)
          2'b01:   nxt = ~cur;
          2'b10:   nxt = 1'b0;
          2'b11:   nxt = 1'b1;
          default: nxt = cur;
        endcase
      end
      CLS_FAST: begin
        if (hit) begin
          if (act == 2'b10) nxt = 1'b0;
          else if (act == 2'b11) nxt = 1'b1;
        end
        if (wrap) begin
          if (act == 2'b10) nxt = 1'b1;
          else if (act == 2'b11) nxt = 1'b0;
        end
      end
      CLS_PHASE: if (hit) begin
        if (act == 2'b10) nxt = ~rising;
        else if (act == 2'b11) nxt = rising;
      end
      default: nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/wt_counter.sv
module wt_counter import wt_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [2:0]   mode,
  input  logic [W-1:0] top_cmp,
  input  logic         wr_cnt,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cnt,
  output logic         dir_up,
  output logic         step,
  output logic         ev_wrap,
  output logic         ev_ptop,
  output logic         ev_ovf
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  mode_cls_t    cls;
  logic [W-1:0] top;
  logic         at_top, at_max, at_bot;
  logic         up_cls, ev_pbot, ev_attop, ev_atmax;
  logic [W-1:0] cnt_d;
  logic         dir_d;

  assign cls    = cls_of(mode);
  assign top    = top_from_cmp(mode) ? top_cmp : MAXV;
  assign at_top = (cnt == top);
  assign at_max = (cnt == MAXV);
  assign at_bot = (cnt == ZERO);
  assign up_cls = (cls == CLS_PLAIN) || (cls == CLS_FAST);
  assign step   = tick && !wr_cnt && (cls != CLS_HALT);

  assign ev_wrap  = step && up_cls && (at_top || at_max);
  assign ev_attop = step && up_cls && at_top;
  assign ev_atmax = step && up_cls && at_max;
  assign ev_ptop  = step && (cls == CLS_PHASE) && dir_up && at_top;
  assign ev_pbot  = step && (cls == CLS_PHASE) && !dir_up && at_bot;

  always_comb begin
    case (ovf_point(mode))
      OV_MAX:  ev_ovf = ev_atmax;
      OV_TOP:  ev_ovf = ev_attop;
      OV_BOT:  ev_ovf = ev_pbot;
      default: ev_ovf = 1'b0;
    endcase
  end

  always_comb begin
    cnt_d = cnt;
    dir_d = dir_up;
    if (wr_cnt) begin
      cnt_d = wr_data;
    end else if (step) begin
      if (cls == CLS_PHASE) begin
        if (dir_up) begin
          if (at_top) begin
            dir_d = 1'b0;
            cnt_d = at_bot ? cnt : cnt - ONE;
          end else begin
            cnt_d = cnt + ONE;
          end
        end else begin
          if (at_bot) begin
            dir_d = 1'b1;
            cnt_d = (top == ZERO) ? cnt : ONE;
          end else begin
            cnt_d = cnt - ONE;
          end
        end
      end else begin
        dir_d = 1'b1;
        cnt_d = ev_wrap ? ZERO : cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= ZERO;
      dir_up <= 1'b1;
    end else begin
      cnt    <= cnt_d;
      dir_up <= dir_d;
    end
  end

  assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && up_cls && !at_top && !at_max) |=> (cnt == $past(cnt) + ONE));

  assert_phase_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && (cls == CLS_PHASE) && dir_up && at_top && !at_bot)
      |=> (!dir_up && cnt == $past(cnt) - ONE));

  assert_halt_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls == CLS_HALT) && !wr_cnt) |=> $stable(cnt));

endmodule

// File: rtl/wt_channel.sv
module wt_channel import wt_pkg::*; #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode,
  input  logic [1:0]   act_sel,
  input  logic [W-1:0] cnt,
  input  logic         dir_up,
  input  logic         step,
  input  logic         block,
  input  logic         ev_wrap,
  input  logic         ev_ptop,
  input  logic         wr_cmp,
  input  logic [W-1:0] wr_data,
  input  logic         force_req,
  output logic [W-1:0] cmp_buf,
  output logic [W-1:0] cmp_act,
  output logic         ev_match,
  output logic         wave
);
  mode_cls_t    cls;
  logic [W-1:0] buf_d, act_d;
  logic         load, hit, force_ok, wave_q;

  assign cls      = cls_of(mode);
  assign buf_d    = wr_cmp ? wr_data : cmp_buf;
  assign load     = (cls == CLS_FAST)  ? ev_wrap :
                    (cls == CLS_PHASE) ? ev_ptop : 1'b1;
  assign act_d    = load ? buf_d : cmp_act;
  assign ev_match = step && !block && (cnt == cmp_act);
  assign force_ok = force_req && (cls == CLS_PLAIN);
  assign hit      = ev_match || force_ok;
  assign wave     = (act_sel != 2'b00) && wave_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
      wave_q  <= 1'b0;
    end else begin
      cmp_buf <= buf_d;
      cmp_act <= act_d;
      wave_q  <= wave_next(cls, act_sel, wave_q, hit,
                           ev_wrap && (cls == CLS_FAST), dir_up);
    end
  end

  assert_buf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cls == CLS_FAST) && !ev_wrap) |=> (cmp_act == $past(cmp_act)));

  assert_quiet_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !(force_req && (cls == CLS_PLAIN))) |=> (wave_q == $past(wave_q)));

endmodule

// File: rtl/wt_flags.sv
module wt_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_ev,
  input  logic          clr_wr,
  input  logic [NF-1:0] clr_mask,
  output logic [NF-1:0] flags
);
  logic [NF-1:0] clr;

  assign clr = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set_ev;
  end

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ev) |=> ((flags & $past(set_ev)) == $past(set_ev)));

endmodule

// File: rtl/wavetimer8.sv
module wavetimer8 import wt_pkg::*; #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  rd_data,
  output logic          wave_a,
  output logic          wave_b
);
  localparam int NCH = 2;
  localparam int NF  = NCH + 1;
  localparam logic [AW-1:0] A_CFG = AW'(0);
  localparam logic [AW-1:0] A_FRC = AW'(1);
  localparam logic [AW-1:0] A_CNT = AW'(2);
  localparam int            A_CMP = 3;
  localparam logic [AW-1:0] A_FLG = AW'(5);

  logic [2:0]    mode_q;
  logic [1:0]    act_sel [NCH];
  logic [W-1:0]  cbuf    [NCH];
  logic [W-1:0]  cact    [NCH];
  logic [NCH-1:0] match, wv;
  logic [NF-1:0] flags;
  logic [W-1:0]  cnt;
  logic          dir_up, step, ev_wrap, ev_ptop, ev_ovf;
  logic          wr_cnt, wr_frc, wr_cfg, blk;

  assign wr_cnt = wr_en && (addr == A_CNT);
  assign wr_frc = wr_en && (addr == A_FRC);
  assign wr_cfg = wr_en && (addr == A_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      act_sel[0] <= '0;
      act_sel[1] <= '0;
      blk        <= 1'b0;
    end else begin
      if (wr_cfg) begin
        mode_q     <= wr_data[2:0];
        act_sel[0] <= wr_data[4:3];
        act_sel[1] <= wr_data[6:5];
      end
      if (wr_cnt)    blk <= 1'b1;
      else if (step) blk <= 1'b0;
    end
  end

  wt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cnt_en), .mode(mode_q), .top_cmp(cact[0]),
    .wr_cnt(wr_cnt), .wr_data(wr_data), .cnt(cnt), .dir_up(dir_up), .step(step),
    .ev_wrap(ev_wrap), .ev_ptop(ev_ptop), .ev_ovf(ev_ovf)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wt_channel #(.W(W)) u_ch (
      .clk(clk), .rst_n(rst_n), .mode(mode_q), .act_sel(act_sel[i]), .cnt(cnt),
      .dir_up(dir_up), .step(step), .block(blk), .ev_wrap(ev_wrap), .ev_ptop(ev_ptop),
      .wr_cmp(wr_en && (addr == AW'(A_CMP + i))), .wr_data(wr_data),
      .force_req(wr_frc && wr_data[i]), .cmp_buf(cbuf[i]), .cmp_act(cact[i]),
      .ev_match(match[i]), .wave(wv[i])
    );
  end

  wt_flags #(.NF(NF)) u_flg (
    .clk(clk), .rst_n(rst_n), .set_ev({match, ev_ovf}),
    .clr_wr(wr_en && (addr == A_FLG)), .clr_mask(wr_data[NF-1:0]), .flags(flags)
  );

  assign wave_a = wv[0];
  assign wave_b = wv[1];

  always_comb begin
    rd_data = '0;
    if (addr == A_CFG)                rd_data = W'({act_sel[1], act_sel[0], mode_q});
    else if (addr == A_CNT)           rd_data = cnt;
    else if (addr == AW'(A_CMP))      rd_data = cbuf[0];
    else if (addr == AW'(A_CMP + 1))  rd_data = cbuf[1];
    else if (addr == A_FLG)           rd_data = W'(flags);
  end

  assert_wr_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (match == '0));

  assert_force_no_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frc && !cnt_en) |=> (flags == $past(flags)));

endmodule

// File: tb/sim_wavetimer8.sv
module sim_wavetimer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       wave_a, wave_b;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] CFG = 3'd0, FRC = 3'd1, CNT = 3'd2, CMA = 3'd3, CMB = 3'd4, FLG = 3'd5;

  wavetimer8 u0 (.clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
                 .wr_data(wr_data), .rd_data(rd_data), .wave_a(wave_a), .wave_b(wave_b));

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic tick(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 register after reset", v, 0);
    end
    check("R1 pin a after reset", wave_a, 0);
    check("R1 pin b after reset", wave_b, 0);
  endtask

  task automatic t_plain();
    logic [7:0] v;
    wr(CFG, 8'h00);
    wr(CNT, 8'hFD);
    tick(2);
    rd(CNT, v); check("R2 count steps", v, 8'hFF);
    rd(FLG, v); check("R2 no overflow before MAX", v, 0);
    tick(1);
    rd(CNT, v); check("R2 wrap to zero", v, 0);
    rd(FLG, v); check("R2 overflow at MAX", v, 1);
    wr(FLG, 8'h01);
    rd(FLG, v); check("R11 write one clears", v, 0);
    tick(1);
    rd(FLG, v); check("R3 both match flags at zero", v, 8'h06);
    wr(FLG, 8'h02);
    rd(FLG, v); check("R11 clear only selected bit", v, 8'h04);
    wr(FLG, 8'h07);
  endtask

  task automatic t_ctc();
    logic [7:0] v;
    wr(CMA, 8'h05);
    wr(CFG, 8'h0A);
    wr(CNT, 8'h00);
    tick(5);
    rd(CNT, v); check("R3 count reaches compare", v, 5);
    check("R7 pin before match", wave_a, 0);
    tick(1);
    rd(CNT, v); check("R3 clear after compare A", v, 0);
    check("R7 toggle on match", wave_a, 1);
    rd(FLG, v); check("R3 match A flag only", v, 8'h02);
    tick(6);
    rd(CNT, v); check("R3 second period", v, 0);
    check("R7 toggle back", wave_a, 0);
    wr(FLG, 8'h07);
  endtask

  task automatic t_force();
    logic [7:0] v;
    wr(CFG, 8'h5A);
    wr(CNT, 8'h03);
    wr(FRC, 8'h03);
    check("R10 force sets pin a", wave_a, 1);
    check("R10 force clears pin b", wave_b, 0);
    rd(CNT, v); check("R10 force keeps count", v, 3);
    rd(FLG, v); check("R10 force sets no flag", v, 0);
    rd(FRC, v); check("R10 force reads zero", v, 0);
    wr(CFG, 8'h7A);
    wr(FRC, 8'h02);
    check("R7 force with set action", wave_b, 1);
    wr(CFG, 8'h5A);
    wr(FRC, 8'h02);
    check("R7 force with clear action", wave_b, 0);
    wr(CFG, 8'h13);
    wr(FRC, 8'h01);
    check("R10 force ignored in fast PWM", wave_a, 1);
  endtask

  task automatic t_fast();
    logic [7:0] v;
    wr(CFG, 8'h10);
    wr(CMA, 8'h10);
    wr(CFG, 8'h13);
    wr(CNT, 8'hFE);
    tick(2);
    check("R8 set at wrap", wave_a, 1);
    wr(CMA, 8'h05);
    rd(CMA, v); check("R6 read returns buffer", v, 8'h05);
    tick(6);
    check("R6 old compare still active", wave_a, 1);
    tick(11);
    rd(CNT, v); check("R2 fast count", v, 8'h11);
    check("R8 clear on match", wave_a, 0);
    wr(CNT, 8'hFF);
    tick(1);
    check("R8 set at next wrap", wave_a, 1);
    tick(5);
    check("R6 new compare not yet hit", wave_a, 1);
    tick(1);
    check("R6 new compare after wrap", wave_a, 0);
    wr(CFG, 8'h10);
    wr(CMA, 8'h03);
    wr(CFG, 8'h17);
    wr(FLG, 8'h07);
    wr(CNT, 8'h00);
    tick(3);
    rd(FLG, v); check("R4 no overflow before top", v & 8'h01, 0);
    check("R8 pin low before top", wave_a, 0);
    tick(1);
    rd(CNT, v); check("R4 restart at top", v, 0);
    rd(FLG, v); check("R4 overflow at top", v & 8'h03, 8'h03);
    check("R8 wrap wins over match", wave_a, 1);
    tick(4);
    check("R8 pin stays high", wave_a, 1);
  endtask

  task automatic t_phase();
    logic [7:0] v;
    wr(CFG, 8'h00);
    wr(CMA, 8'h04);
    wr(CMB, 8'h02);
    wr(FLG, 8'h07);
    wr(CFG, 8'h45);
    wr(CNT, 8'h00);
    tick(6);
    rd(CNT, v); check("R5 falling after top", v, 2);
    check("R9 low after rising match", wave_b, 0);
    tick(1);
    check("R9 high on falling match", wave_b, 1);
    tick(1);
    rd(FLG, v); check("R5 no overflow before bottom", v & 8'h01, 0);
    tick(1);
    rd(CNT, v); check("R5 turn at bottom", v, 1);
    rd(FLG, v); check("R5 overflow at bottom", v & 8'h01, 1);
    tick(2);
    rd(CNT, v); check("R5 rising again", v, 3);
    check("R9 low on rising match", wave_b, 0);
  endtask

  task automatic t_block();
    logic [7:0] v;
    wr(CFG, 8'h0A);
    wr(CMA, 8'h05);
    wr(FLG, 8'h07);
    wr(CNT, 8'h05);
    tick(1);
    rd(CNT, v); check("R12 period still ends", v, 0);
    rd(FLG, v); check("R12 match hidden after count write", v, 0);
    check("R12 pin unchanged", wave_a, 1);
    tick(6);
    rd(FLG, v); check("R12 later match counts", (v >> 1) & 8'h01, 1);
    check("R12 later toggle", wave_a, 0);
  endtask

  task automatic t_disc();
    wr(CFG, 8'h1A);
    wr(FRC, 8'h01);
    check("R13 pin high when connected", wave_a, 1);
    wr(CFG, 8'h02);
    check("R13 pin low when disconnected", wave_a, 0);
    wr(CFG, 8'h1A);
    check("R13 state kept", wave_a, 1);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(CFG, 8'h04);
    wr(FLG, 8'h07);
    wr(CNT, 8'h20);
    tick(5);
    rd(CNT, v); check("R14 mode 4 holds", v, 8'h20);
    wr(CFG, 8'h06);
    tick(5);
    rd(CNT, v); check("R14 mode 6 holds", v, 8'h20);
    rd(FLG, v); check("R14 no flags", v, 0);
    rd(CFG, v); check("R1 config readback", v, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_ctc();
    t_force();
    t_fast();
    t_phase();
    t_block();
    t_disc();
    t_reserved();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got %0h expected %0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule